// File: doc/BRIEF.md
# Receive Runt Filter and DMA-Start Gate

This block watches the byte stream that a MAC hands to the receive FIFO and decides two things for every frame: whether the frame is kept, and the cycle in which the receive DMA engine may start moving it. It has two modes.

In strict mode, short frames are dropped. A frame of fewer than 64 bytes produces a one-cycle discard strobe and never starts DMA. A longer frame starts DMA once its 64th byte has arrived. In normal mode, every frame is kept. DMA starts as soon as the FIFO level reaches a programmable watermark, or when the frame ends, whichever happens first.

Strict mode applies only when a stored runt-reject bit is set and the link runs full duplex. The mode is fixed at each frame's first byte. The runt-reject bit is cleared only by the hard reset. The soft clear abandons the frame in progress and leaves the bit as it is.

Top module: `rx_runt_gate`

## Requirements
- R1: After hard reset (`rst_n` low at a clock edge), `dma_start` and `frame_drop` are 0 and the runt-reject bit is 0. A short full-duplex frame received next is therefore accepted.
- R2: A clock edge with `cfg_we` high loads `cfg_runt_rej` into the runt-reject bit. `soft_clr` does not change that bit.
- R3: A frame runs in strict mode only when the runt-reject bit and `full_duplex` are both 1 at its start-of-frame beat. Any other combination gives normal mode for the whole frame.
- R4: In strict mode, a frame whose end-of-frame beat is its 1st to 63rd byte makes `frame_drop` high for exactly the one cycle after that beat. `dma_start` stays 0 for that frame.
- R5: In strict mode, `dma_start` rises in the cycle after the frame's 64th byte beat. This also holds when that beat carries end-of-frame.
- R6: In normal mode, `dma_start` rises in the cycle after any cycle that is inside a frame (after its start beat) and has `fifo_level` >= `fifo_wmark` (unsigned compare).
- R7: In normal mode, the end-of-frame beat raises `dma_start` in the next cycle if it is not already high, even when the watermark is not reached. `frame_drop` is never raised in normal mode.
- R8: `dma_start` is a single request per frame and stays high until the next start-of-frame beat. It falls in the cycle after that beat, unless that beat itself meets a start condition.
- R9: The per-frame byte count saturates at 64. A frame of any length above 64 is accepted in strict mode with one DMA start.
- R10: `soft_clr` high at an edge abandons the current frame. In the next cycle `dma_start` and `frame_drop` are 0, and beats without start-of-frame are ignored until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_clr | input | 1 | Synchronous frame-state clear; keeps configuration |
| cfg_we | input | 1 | Write strobe for the runt-reject bit |
| cfg_runt_rej | input | 1 | Value written to the runt-reject bit |
| full_duplex | input | 1 | Link runs full duplex |
| fifo_wmark | input | 4 | DMA-start threshold in bytes, normal mode |
| fifo_level | input | 8 | Current receive FIFO occupancy in bytes |
| rx_valid | input | 1 | A byte is delivered this cycle |
| rx_sof | input | 1 | This byte is the first of a frame (with rx_valid) |
| rx_eof | input | 1 | This byte is the last of a frame (with rx_valid) |
| dma_start | output | 1 | Receive DMA may start; held until next start-of-frame |
| frame_drop | output | 1 | One-cycle strobe: current frame discarded as a runt |

## Verification
Two events can fall in the same cycle.

- **End of frame on the 64th byte.** In strict mode the 64-byte threshold and the end of frame coincide. The bench sends exactly 64- and 63-byte frames and expects a DMA start with no strobe for the first, and a strobe with no start for the second.
- **New start-of-frame while a request is held.** The start-of-frame beat of the next frame comes right after the previous end, while `dma_start` is still latched. The clear must win and be visible one cycle later. Single-byte normal frames test the case where clear and set fall on the same beat, and there the set must win.

The behavioural reference model judges every cycle.

// File: rtl/rx_runt_pkg.sv
// Package: shared constants for the receive runt filter.
// Assumes: minimum accepted frame length is 64 bytes.
package rx_runt_pkg;
    localparam int unsigned MIN_FRAME = 64;
    localparam int unsigned CNT_W     = $clog2(MIN_FRAME + 1);
    typedef logic [CNT_W-1:0] len_cnt_t;
endpackage

// File: rtl/rx_runt_cfg.sv
// Module: rx_runt_cfg
// Holds the runt-reject configuration bit. Only the hard reset clears it;
// the frame-level soft clear is deliberately not an input here.
module rx_runt_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_wdata,
    output logic rej_q
);
    // Configuration storage: loaded by write strobe, cleared by hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      rej_q <= 1'b0;
        else if (cfg_we) rej_q <= cfg_wdata;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(rej_q)); // R2
endmodule

// File: rtl/rx_len_counter.sv
// Module: rx_len_counter
// Per-frame byte counter. Loads 1 on a start beat, increments on accepted
// beats, saturates at MIN_LEN. Exposes next value for same-cycle decisions.
module rx_len_counter
    import rx_runt_pkg::*;
#(
    parameter int unsigned MIN_LEN = MIN_FRAME,
    localparam int unsigned CW     = $clog2(MIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sof_beat,
    input  logic          take_beat,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt
);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LEN);
    localparam logic [CW-1:0] ONE   = CW'(1);

    // Next-count selection: restart, saturating increment or hold.
    always_comb begin
        if (sof_beat)                         cnt_nxt = ONE;
        else if (take_beat && cnt_q != LIMIT) cnt_nxt = cnt_q + ONE;
        else                                  cnt_nxt = cnt_q;
    end

    // Count register with hard reset and soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_nxt;
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R9
endmodule

// File: rtl/rx_gate_ctrl.sv
// Module: rx_gate_ctrl
// Frame tracking, mode latch, DMA-start latch and runt discard strobe.
// Assumes rx_sof/rx_eof are meaningful only with rx_valid; beats outside a
// frame (no start seen) are ignored.
module rx_gate_ctrl #(
    parameter int unsigned MIN_LEN = 64,
    parameter int unsigned WM_W    = 4,
    parameter int unsigned LVL_W   = 8,
    localparam int unsigned CW     = $clog2(MIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             rej_q,
    input  logic             full_duplex,
    input  logic [WM_W-1:0]  fifo_wmark,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [CW-1:0]    cnt_q,
    input  logic [CW-1:0]    cnt_nxt,
    output logic             sof_beat,
    output logic             take_beat,
    output logic             dma_start,
    output logic             frame_drop
);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LEN);

    logic in_frame_q;
    logic strict_q;
    logic strict_eff;
    logic eof_beat;
    logic min_hit;
    logic wm_hit;
    logic dma_set;
    logic drop_d;

    // Beat qualification: start beats always count, others only inside a frame.
    always_comb begin
        sof_beat  = rx_valid && rx_sof;
        take_beat = rx_valid && (rx_sof || in_frame_q);
        eof_beat  = take_beat && rx_eof;
    end

    // Mode for the current beat: a start beat samples the new mode.
    always_comb begin
        strict_eff = sof_beat ? (rej_q && full_duplex) : strict_q;
        min_hit    = (cnt_nxt >= LIMIT);
        wm_hit     = ({{(LVL_W > WM_W ? LVL_W - WM_W : 0){1'b0}}, fifo_wmark} <= fifo_level);
    end

    // Start and discard conditions for both modes.
    always_comb begin
        if (strict_eff) begin
            dma_set = take_beat && min_hit;
            drop_d  = eof_beat && !min_hit;
        end else begin
            dma_set = (in_frame_q && wm_hit) || eof_beat;
            drop_d  = 1'b0;
        end
    end

    // Frame-in-progress flag: set by start beat, end beat wins.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) in_frame_q <= 1'b0;
        else if (eof_beat)      in_frame_q <= 1'b0;
        else if (sof_beat)      in_frame_q <= 1'b1;
    end

    // Mode latch, captured once per frame at its start beat.
    always_ff @(posedge clk) begin
        if (!rst_n)        strict_q <= 1'b0;
        else if (sof_beat) strict_q <= rej_q && full_duplex;
    end

    // DMA-start latch: cleared at a start beat, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) dma_start <= 1'b0;
        else if (dma_set)       dma_start <= 1'b1;
        else if (sof_beat)      dma_start <= 1'b0;
    end

    // Discard strobe, one cycle per rejected frame.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) frame_drop <= 1'b0;
        else                    frame_drop <= drop_d;
    end

    AST_DROP_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> !dma_start); // R4
    AST_STRICT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dma_start) && strict_q) |-> (cnt_q == LIMIT)); // R5
    AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_start && !sof_beat && !soft_clr) |=> dma_start); // R8
    AST_SOFT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!dma_start && !frame_drop)); // R10
    AST_NORMAL_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!strict_eff && !soft_clr) |=> !frame_drop); // R7
endmodule

// File: rtl/rx_runt_gate.sv
// Module: rx_runt_gate (top)
// Receive runt filter and DMA-start gate between the MAC byte stream and
// the receive FIFO / DMA request path. Assumes fifo_level is the FIFO
// occupancy as seen in the same cycle.
module rx_runt_gate
    import rx_runt_pkg::*;
#(
    parameter int unsigned MIN_LEN = MIN_FRAME,
    parameter int unsigned WM_W    = 4,
    parameter int unsigned LVL_W   = 8,
    localparam int unsigned CW     = $clog2(MIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             cfg_we,
    input  logic             cfg_runt_rej,
    input  logic             full_duplex,
    input  logic [WM_W-1:0]  fifo_wmark,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             dma_start,
    output logic             frame_drop
);
    logic          rej_q;
    logic          sof_beat;
    logic          take_beat;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    rx_runt_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_runt_rej),
        .rej_q     (rej_q)
    );

    rx_len_counter #(.MIN_LEN(MIN_LEN)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .sof_beat  (sof_beat),
        .take_beat (take_beat),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt)
    );

    rx_gate_ctrl #(.MIN_LEN(MIN_LEN), .WM_W(WM_W), .LVL_W(LVL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr    (soft_clr),
        .rej_q       (rej_q),
        .full_duplex (full_duplex),
        .fifo_wmark  (fifo_wmark),
        .fifo_level  (fifo_level),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .cnt_q       (cnt_q),
        .cnt_nxt     (cnt_nxt),
        .sof_beat    (sof_beat),
        .take_beat   (take_beat),
        .dma_start   (dma_start),
        .frame_drop  (frame_drop)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!dma_start && !frame_drop)); // R1
endmodule

// File: tb/rx_runt_gate_tb_top.sv
module rx_runt_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_runt_rej = 1'b0;
    logic       full_duplex = 1'b0;
    logic [3:0] fifo_wmark = 4'd0;
    logic [7:0] fifo_level = 8'd0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic       rx_eof = 1'b0;
    logic       dma_start;
    logic       frame_drop;

    int checks = 0;
    int fails  = 0;
    int drops  = 0;
    int starts = 0;
    bit done   = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    rx_runt_gate dut_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_we(cfg_we),
        .cfg_runt_rej(cfg_runt_rej), .full_duplex(full_duplex),
        .fifo_wmark(fifo_wmark), .fifo_level(fifo_level),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .dma_start(dma_start), .frame_drop(frame_drop)
    );

    // Behavioural reference model
    int m_cnt = 0;
    bit m_in = 0, m_strict = 0, m_dma = 0, m_drop = 0, m_rej = 0;

    always @(posedge clk) begin
        bit beat, sofb, take, eofb, strict, nd;
        if (!rst_n) begin
            m_cnt = 0; m_in = 0; m_strict = 0; m_dma = 0; m_drop = 0; m_rej = 0;
        end else begin
            beat = rx_valid;
            sofb = beat && rx_sof;
            take = beat && (rx_sof || m_in);
            eofb = take && rx_eof;
            if (soft_clr) begin
                m_in = 0; m_dma = 0; m_drop = 0; m_cnt = 0;
                if (sofb) m_strict = m_rej && full_duplex;
            end else begin
                strict = sofb ? (m_rej && full_duplex) : m_strict;
                if (sofb) m_cnt = 1;
                else if (take && m_cnt < 64) m_cnt = m_cnt + 1;
                nd = sofb ? 1'b0 : m_dma;
                m_drop = 0;
                if (strict) begin
                    if (take && m_cnt >= 64) nd = 1;
                    if (eofb && m_cnt < 64) m_drop = 1;
                end else begin
                    if (m_in && (int'(fifo_level) >= int'(fifo_wmark))) nd = 1;
                    if (eofb) nd = 1;
                end
                m_dma = nd;
                m_strict = strict;
                if (eofb) m_in = 0;
                else if (sofb) m_in = 1;
            end
            if (cfg_we) m_rej = cfg_runt_rej;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(dma_start === m_dma, {cur_req, " dma_start"}, dma_start, m_dma);
            chk(frame_drop === m_drop, {cur_req, " frame_drop"}, frame_drop, m_drop);
            if (frame_drop) drops++;
            if (dma_start && !m_dma) starts++;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            rx_valid = 0; rx_sof = 0; rx_eof = 0; soft_clr = 0; cfg_we = 0;
        end
    endtask

    task automatic send_frame(input int len, input int lvl_off);
        for (int i = 0; i < len; i++) begin
            step();
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            fifo_level = 8'((i + lvl_off) > 255 ? 255 : (i + lvl_off));
        end
        step();
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
    endtask

    task automatic write_rej(input bit v);
        step(); cfg_we = 1; cfg_runt_rej = v;
        step(); cfg_we = 0;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (3) @(posedge clk);
        #2;
        cur_req = "R1";
        chk(dma_start === 1'b0, "R1 reset dma_start", dma_start, 0);
        chk(frame_drop === 1'b0, "R1 reset frame_drop", frame_drop, 0);
        rst_n = 1;
        full_duplex = 1;
        idle(2);
        // R1: reject bit cleared by reset, so short full-duplex frame accepted
        d0 = drops;
        send_frame(10, 0); idle(3);
        chk(dma_start === 1'b1, "R1 short frame accepted after reset", dma_start, 1);
        chk(drops == d0, "R1 no discard after reset", drops - d0, 0);

        // R6: normal mode watermark start
        cur_req = "R6"; fifo_wmark = 4'd5;
        send_frame(30, 0); idle(3);
        chk(dma_start === 1'b1, "R6 watermark start", dma_start, 1);
        // R7: normal frame ending below watermark
        cur_req = "R7"; fifo_wmark = 4'd15;
        send_frame(4, 0); idle(3);
        chk(dma_start === 1'b1, "R7 start at end-of-frame", dma_start, 1);
        // R8: back-to-back single-byte frames (clear and set on same beat)
        cur_req = "R8";
        send_frame(1, 0); send_frame(1, 0); idle(2);
        chk(dma_start === 1'b1, "R8 single-byte frame", dma_start, 1);

        // R3: reject bit set but half duplex -> normal mode
        cur_req = "R3"; write_rej(1); full_duplex = 0; fifo_wmark = 4'd15;
        d0 = drops;
        send_frame(20, 0); idle(3);
        chk(drops == d0 && dma_start === 1'b1, "R3 half duplex keeps short frame", drops - d0, 0);

        // R4: strict mode short frame dropped
        cur_req = "R4"; full_duplex = 1;
        d0 = drops;
        send_frame(20, 0); idle(3);
        chk(drops == d0 + 1, "R4 one discard strobe", drops - d0, 1);
        chk(dma_start === 1'b0, "R4 no dma for runt", dma_start, 0);
        // R4: 63-byte boundary
        d0 = drops;
        send_frame(63, 0); idle(3);
        chk(drops == d0 + 1, "R4 63-byte discard", drops - d0, 1);
        // R5: exactly 64 bytes, end on threshold beat
        cur_req = "R5"; d0 = drops;
        send_frame(64, 0); idle(3);
        chk(dma_start === 1'b1 && drops == d0, "R5 64-byte accepted", dma_start, 1);
        // R9: long frame with saturation, back-to-back frames
        cur_req = "R9"; d0 = drops;
        send_frame(150, 0); send_frame(70, 0); idle(3);
        chk(dma_start === 1'b1 && drops == d0, "R9 long frames accepted", drops - d0, 0);
        // R8: strict start beat clears held request the following cycle
        cur_req = "R8";
        step(); rx_valid = 1; rx_sof = 1; rx_eof = 0;
        step(); rx_sof = 0;
        #1 chk(dma_start === 1'b0, "R8 cleared after start beat", dma_start, 1'b0);
        for (int i = 0; i < 10; i++) step();
        // R10: soft clear mid-frame
        cur_req = "R10";
        soft_clr = 1;
        step(); soft_clr = 0;
        for (int i = 0; i < 70; i++) step();
        rx_valid = 0;
        idle(2);
        chk(dma_start === 1'b0, "R10 orphan beats ignored", dma_start, 0);
        // R2: reject bit survives soft clear
        cur_req = "R2"; d0 = drops;
        send_frame(30, 0); idle(3);
        chk(drops == d0 + 1, "R2 reject bit kept through soft clear", drops - d0, 1);
        // R2: clear by write
        write_rej(0); d0 = drops;
        send_frame(30, 0); idle(3);
        chk(drops == d0 && dma_start === 1'b1, "R2 reject bit written to 0", drops - d0, 0);
        // R1: hard reset clears reject bit
        cur_req = "R1"; write_rej(1);
        step(); rst_n = 0; step(); rst_n = 1; idle(2);
        d0 = drops;
        send_frame(12, 0); idle(3);
        chk(drops == d0 && dma_start === 1'b1, "R1 hard reset cleared reject", drops - d0, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule